// File: doc/BRIEF.md
# Banked Private Interrupt Pending Tracker

This block keeps the pending and active state of the sixteen private peripheral interrupts (IDs 16 to 31) for each of several CPUs. Each CPU owns a private copy of a two-word trigger configuration. That configuration decides, for every interrupt, whether it behaves as level-sensitive or as edge-triggered. The trigger mode controls how a pending bit goes away. A level-sensitive interrupt is pending exactly while its line is high, and an acknowledge does not remove it. An edge-triggered interrupt latches on a rising edge and stays latched when its line drops. Only an acknowledge or a software clear-pending write removes it.

Each interrupt of each CPU is one small state machine. The state is the pair {active, pending}, with four named states. ST_IDLE holds neither bit. ST_PEND is pending only. ST_ACT is active only. ST_ACT_PEND is both. Every transition happens on a clock edge. The next pending bit comes from the trigger rules of R5, R6, R7 and R9. The next active bit is set by an acknowledge and cleared by an end-of-interrupt (R7, R8). For example, ST_IDLE goes to ST_PEND when the line is sampled high in level mode, or on a rising edge in edge mode. ST_PEND goes to ST_ACT_PEND on an acknowledge in level mode, and to ST_ACT on an acknowledge in edge mode. ST_ACT_PEND goes to ST_PEND on an end-of-interrupt. In level mode, any pending state drops its pending half when the line is released. A write that selects the unsupported N:N handling model raises a one-cycle flag.

Top module: `ppi_pend_tracker`

## Requirements
- R1: Each CPU has two 32-bit configuration words, with two bits per interrupt ID 0 to 31. ID n sits in word n/16 at bits [2*(n%16)+1 : 2*(n%16)]. The upper bit of a field is 1 for edge-triggered and 0 for level-sensitive. Word 1 resets to 0, so all private interrupts start level-sensitive.
- R2: Word 0 is read-only and always reads 32'hAAAA_AAAA. Writes to word 0 are discarded.
- R3: A read returns the addressed CPU's own word. A write to one CPU's word 1 leaves every other CPU's word 1 unchanged.
- R4: For CPU c and interrupt ID d, the bit in the flat pending, active, line and per-CPU clear-mask vectors is c*16 + (d-16).
- R5: For a level-sensitive interrupt, the pending bit equals the line as sampled at the previous clock edge. It is set one cycle after the line is high, cleared one cycle after the line is released, and an acknowledge leaves it set.
- R6: For an edge-triggered interrupt, a rising edge of the line sets the pending bit one cycle later. Releasing the line does not clear it.
- R7: An acknowledge for CPU c and ID d (16 to 31) sets that interrupt's active bit one cycle later. It clears the pending bit only if the interrupt is edge-triggered. An acknowledge carrying an ID below 16 changes nothing.
- R8: An end-of-interrupt for CPU c and ID d clears only that interrupt's active bit, one cycle later. When an acknowledge of the same interrupt arrives in the same cycle, the acknowledge wins.
- R9: A clear-pending write for CPU c with a 16-bit mask clears, one cycle later, the pending bits of that CPU's edge-triggered interrupts selected by the mask. A rising edge in the same cycle wins over the clear.
- R10: A configuration write to either word whose data has a 1 in the lower bit of any field (mask 32'h5555_5555) selects the N:N model. In that case `nn_unsupported` is high for exactly the following cycle.
- R11: Reset clears all pending and active bits for every CPU, and resets every word 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_CPU*16 | Private interrupt lines, bit c*16+(ID-16) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | CPU of the acknowledge |
| ack_id | input | 5 | Interrupt ID of the acknowledge |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | CPU_W | CPU of the end-of-interrupt |
| eoi_id | input | 5 | Interrupt ID of the end-of-interrupt |
| clrp_valid | input | 1 | Software clear-pending write strobe |
| clrp_cpu | input | CPU_W | CPU of the clear-pending write |
| clrp_mask | input | 16 | Bit k clears pending of ID 16+k |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_cpu | input | CPU_W | CPU bank addressed for read and write |
| cfg_word | input | 1 | Configuration word select (0 or 1) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| pend_o | output | NUM_CPU*16 | Pending vector |
| act_o | output | NUM_CPU*16 | Active vector |
| nn_unsupported | output | 1 | One-cycle pulse after a write that selects N:N |

## Verification
Every registered result is due one clock edge after the stimulus is presented: pending, active, the stored configuration word and the N:N pulse. Configuration read data follows the address within the same cycle. The bench changes inputs at falling edges, so the next rising edge captures them. It samples registered outputs at the following falling edge, half a period after that capture. It samples read data a short delay after the address changes. Release of a line, the pulse width of the N:N flag, and persistence of an edge-triggered pending bit are all checked across additional falling edges, so that a result one cycle early or late is caught.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int          PPI_BASE        = 16;
    localparam int          ID_W            = 5;
    localparam int          CFG_W           = 32;
    localparam logic [31:0] CFG_WORD0_FIXED = 32'hAAAA_AAAA;
    localparam logic [31:0] NN_SEL_MASK     = 32'h5555_5555;

    // encoding is {active, pending}
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_PEND     = 2'b01,
        ST_ACT      = 2'b10,
        ST_ACT_PEND = 2'b11
    } cell_state_t;
endpackage

// File: rtl/ppi_cfg_bank.sv
module ppi_cfg_bank
    import ppi_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_PPI = 16,
    parameter int CPU_W   = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CPU_W-1:0]           cpu_sel,
    input  logic                       word_sel,
    input  logic [CFG_W-1:0]           wdata,
    output logic [CFG_W-1:0]           rdata,
    output logic [NUM_CPU*NUM_PPI-1:0] edge_mode,
    output logic                       nn_flag
);
    logic [NUM_CPU-1:0][CFG_W-1:0] word1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word1_q <= '0;
            nn_flag <= 1'b0;
        end else begin
            nn_flag <= wr_en && ((wdata & NN_SEL_MASK) != '0);
            if (wr_en && word_sel)
                word1_q[cpu_sel] <= wdata;
        end
    end

    always_comb begin
        rdata = word_sel ? word1_q[cpu_sel] : CFG_WORD0_FIXED;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_PPI; i++) begin : g_fld
            assign edge_mode[c*NUM_PPI+i] = word1_q[c][2*i+1];
        end
    end

    assert_word0_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && word_sel) |=> $stable(word1_q));
    assert_nn_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wdata & NN_SEL_MASK) != '0)) |=> nn_flag);
    assert_nn_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !nn_flag);
endmodule

// File: rtl/ppi_cell.sv
module ppi_cell
    import ppi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic edge_mode_i,
    input  logic ack_i,
    input  logic eoi_i,
    input  logic clr_i,
    output logic pend_o,
    output logic act_o
);
    cell_state_t state_q, state_d;
    logic        line_q;
    logic        rise;
    logic        nxt_p, nxt_a;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:     begin pend_o = 1'b0; act_o = 1'b0; end
            ST_PEND:     begin pend_o = 1'b1; act_o = 1'b0; end
            ST_ACT:      begin pend_o = 1'b0; act_o = 1'b1; end
            ST_ACT_PEND: begin pend_o = 1'b1; act_o = 1'b1; end
            default:     begin pend_o = 1'b0; act_o = 1'b0; end
        endcase
    end

    always_comb begin
        rise    = line_i & ~line_q;
        nxt_p   = edge_mode_i ? (rise | (pend_o & ~ack_i & ~clr_i)) : line_i;
        nxt_a   = ack_i | (act_o & ~eoi_i);
        state_d = cell_state_t'({nxt_a, nxt_p});
    end

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i |=> (pend_o == $past(line_i)));
    assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && pend_o && !ack_i && !clr_i) |=> pend_o);
    assert_edge_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && ack_i && !(line_i && !line_q)) |=> !pend_o);
    assert_ack_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> act_o);
    assert_eoi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i) |=> !act_o);
    assert_edge_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && clr_i && !(line_i && !line_q)) |=> !pend_o);
endmodule

// File: rtl/ppi_pend_tracker.sv
module ppi_pend_tracker
    import ppi_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_PPI = 16,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int VEC_W  = NUM_CPU * NUM_PPI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VEC_W-1:0]   irq_line,
    input  logic               ack_valid,
    input  logic [CPU_W-1:0]   ack_cpu,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               eoi_valid,
    input  logic [CPU_W-1:0]   eoi_cpu,
    input  logic [ID_W-1:0]    eoi_id,
    input  logic               clrp_valid,
    input  logic [CPU_W-1:0]   clrp_cpu,
    input  logic [NUM_PPI-1:0] clrp_mask,
    input  logic               cfg_wr_en,
    input  logic [CPU_W-1:0]   cfg_cpu,
    input  logic               cfg_word,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic [VEC_W-1:0]   pend_o,
    output logic [VEC_W-1:0]   act_o,
    output logic               nn_unsupported
);
    logic [VEC_W-1:0] edge_mode;

    ppi_cfg_bank #(
        .NUM_CPU (NUM_CPU),
        .NUM_PPI (NUM_PPI),
        .CPU_W   (CPU_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .cpu_sel   (cfg_cpu),
        .word_sel  (cfg_word),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .edge_mode (edge_mode),
        .nn_flag   (nn_unsupported)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_PPI; i++) begin : g_irq
            localparam int           BIT = c*NUM_PPI + i;
            localparam logic [ID_W-1:0] MY_ID = ID_W'(PPI_BASE + i);
            logic hit_ack, hit_eoi, hit_clr;

            assign hit_ack = ack_valid  && (ack_cpu  == CPU_W'(c)) && (ack_id == MY_ID);
            assign hit_eoi = eoi_valid  && (eoi_cpu  == CPU_W'(c)) && (eoi_id == MY_ID);
            assign hit_clr = clrp_valid && (clrp_cpu == CPU_W'(c)) && clrp_mask[i];

            ppi_cell u_cell (
                .clk         (clk),
                .rst_n       (rst_n),
                .line_i      (irq_line[BIT]),
                .edge_mode_i (edge_mode[BIT]),
                .ack_i       (hit_ack),
                .eoi_i       (hit_eoi),
                .clr_i       (hit_clr),
                .pend_o      (pend_o[BIT]),
                .act_o       (act_o[BIT])
            );
        end
    end
endmodule

// File: tb/ppi_pend_tracker_tb.sv
module ppi_pend_tracker_tb;
    localparam int NUM_CPU = 2;
    localparam int NUM_PPI = 16;
    localparam int VEC_W   = NUM_CPU * NUM_PPI;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [VEC_W-1:0]   irq_line = '0;
    logic               ack_valid = 1'b0;
    logic [0:0]         ack_cpu = '0;
    logic [4:0]         ack_id = '0;
    logic               eoi_valid = 1'b0;
    logic [0:0]         eoi_cpu = '0;
    logic [4:0]         eoi_id = '0;
    logic               clrp_valid = 1'b0;
    logic [0:0]         clrp_cpu = '0;
    logic [15:0]        clrp_mask = '0;
    logic               cfg_wr_en = 1'b0;
    logic [0:0]         cfg_cpu = '0;
    logic               cfg_word = 1'b0;
    logic [31:0]        cfg_wdata = '0;
    logic [31:0]        cfg_rdata;
    logic [VEC_W-1:0]   pend_o, act_o;
    logic               nn_unsupported;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ppi_pend_tracker #(.NUM_CPU(NUM_CPU), .NUM_PPI(NUM_PPI)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
        .clrp_valid(clrp_valid), .clrp_cpu(clrp_cpu), .clrp_mask(clrp_mask),
        .cfg_wr_en(cfg_wr_en), .cfg_cpu(cfg_cpu), .cfg_word(cfg_word),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pend_o(pend_o), .act_o(act_o), .nn_unsupported(nn_unsupported)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
        end
    endtask

    task automatic rd_cfg(input logic cpu, input logic word, output logic [31:0] v);
        cfg_cpu  = cpu;
        cfg_word = word;
        #1;
        v = cfg_rdata;
    endtask

    task automatic wr_cfg(input logic cpu, input logic word, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_cpu = cpu; cfg_word = word; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        chk("R11", "pend after reset", pend_o, 32'h0);
        chk("R11", "act after reset", act_o, 32'h0);
        rd_cfg(1'b0, 1'b1, v); chk("R1", "cpu0 word1 reset", v, 32'h0);
        rd_cfg(1'b1, 1'b1, v); chk("R1", "cpu1 word1 reset", v, 32'h0);
        rd_cfg(1'b0, 1'b0, v); chk("R2", "word0 value", v, 32'hAAAA_AAAA);
        chk("R10", "nn idle", {31'b0, nn_unsupported}, 32'h0);
    endtask

    // cpu0 ID 20 -> bit 4, level-sensitive
    task automatic t_level;
        irq_line[4] = 1'b1;
        @(negedge clk);
        chk("R5", "level pend on high", pend_o, 32'h0000_0010);
        chk("R4", "bit position cpu0 id20", pend_o, 32'h0000_0010);
        ack_valid = 1'b1; ack_cpu = 1'b0; ack_id = 5'd20;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R7", "level ack sets active", act_o, 32'h0000_0010);
        chk("R5", "level ack keeps pending", pend_o, 32'h0000_0010);
        irq_line[4] = 1'b0;
        @(negedge clk);
        chk("R5", "level release clears", pend_o, 32'h0);
        eoi_valid = 1'b1; eoi_cpu = 1'b0; eoi_id = 5'd20;
        @(negedge clk);
        eoi_valid = 1'b0;
        chk("R8", "eoi clears active", act_o, 32'h0);
    endtask

    task automatic t_cfg;
        logic [31:0] v;
        wr_cfg(1'b1, 1'b1, 32'h0000_0080);   // cpu1 ID19 edge
        chk("R10", "no nn on edge-only write", {31'b0, nn_unsupported}, 32'h0);
        rd_cfg(1'b1, 1'b1, v); chk("R3", "cpu1 word1 readback", v, 32'h0000_0080);
        rd_cfg(1'b0, 1'b1, v); chk("R3", "cpu0 word1 untouched", v, 32'h0);
        wr_cfg(1'b1, 1'b0, 32'h0);
        rd_cfg(1'b1, 1'b0, v); chk("R2", "word0 write discarded", v, 32'hAAAA_AAAA);
        wr_cfg(1'b0, 1'b0, 32'h0000_0001);
        chk("R10", "nn pulse on word0 write", {31'b0, nn_unsupported}, 32'h1);
        rd_cfg(1'b0, 1'b0, v); chk("R2", "word0 still fixed", v, 32'hAAAA_AAAA);
        @(negedge clk);
        chk("R10", "nn pulse one cycle", {31'b0, nn_unsupported}, 32'h0);
        wr_cfg(1'b0, 1'b1, 32'h0000_0004);
        chk("R10", "nn pulse on word1 write", {31'b0, nn_unsupported}, 32'h1);
        rd_cfg(1'b0, 1'b1, v); chk("R1", "word1 accepts nn data", v, 32'h0000_0004);
        wr_cfg(1'b0, 1'b1, 32'h0);
    endtask

    // cpu1 ID19 -> bit 19, edge-triggered
    task automatic t_edge;
        irq_line[19] = 1'b1;
        @(negedge clk);
        chk("R6", "edge rise sets pend", pend_o, 32'h0008_0000);
        irq_line[19] = 1'b0;
        @(negedge clk);
        chk("R6", "edge release keeps pend", pend_o, 32'h0008_0000);
        @(negedge clk);
        chk("R6", "edge pend persists", pend_o, 32'h0008_0000);
        ack_valid = 1'b1; ack_cpu = 1'b1; ack_id = 5'd19;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R7", "edge ack clears pend", pend_o, 32'h0);
        chk("R7", "edge ack sets active", act_o, 32'h0008_0000);
        eoi_valid = 1'b1; eoi_cpu = 1'b1; eoi_id = 5'd19;
        @(negedge clk);
        eoi_valid = 1'b0;
        chk("R8", "edge eoi clears active", act_o, 32'h0);
        irq_line[19] = 1'b1;
        @(negedge clk);
        irq_line[19] = 1'b0;
        ack_valid = 1'b1; ack_cpu = 1'b1; ack_id = 5'd3;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R7", "ack id<16 no pend change", pend_o, 32'h0008_0000);
        chk("R7", "ack id<16 no active", act_o, 32'h0);
        clrp_valid = 1'b1; clrp_cpu = 1'b0; clrp_mask = 16'h0008;
        @(negedge clk);
        chk("R4", "clear on other cpu ignored", pend_o, 32'h0008_0000);
        clrp_cpu = 1'b1;
        @(negedge clk);
        clrp_valid = 1'b0;
        chk("R9", "clear-pending edge", pend_o, 32'h0);
        irq_line[19] = 1'b1;
        clrp_valid = 1'b1; clrp_cpu = 1'b1; clrp_mask = 16'h0008;
        @(negedge clk);
        chk("R9", "rise wins over clear", pend_o, 32'h0008_0000);
        @(negedge clk);
        clrp_valid = 1'b0;
        chk("R9", "clear with line still high", pend_o, 32'h0);
        irq_line[19] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_clears;
        logic [31:0] v;
        irq_line[4] = 1'b1;
        ack_valid = 1'b1; ack_cpu = 1'b0; ack_id = 5'd20;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R7", "pre-reset active", act_o, 32'h0000_0010);
        rst_n = 1'b0;
        irq_line = '0;
        @(negedge clk);
        chk("R11", "reset clears pend", pend_o, 32'h0);
        chk("R11", "reset clears act", act_o, 32'h0);
        rd_cfg(1'b1, 1'b1, v); chk("R11", "reset clears word1", v, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_level();
        t_cfg();
        t_edge();
        t_reset_clears();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule